// File: doc/BRIEF.md
# Random-Access Scan State Array

This block is a bank of single-bit state flip-flops that drives a piece of functional logic in normal operation and can be reached one cell at a time during test. In normal mode every cell takes its next state from a parallel functional input bus on the system clock, and the cell states leave the block on a parallel output bus that feeds the functional logic directly.

In test mode, a tester first loads a cell address through a one-bit serial input. The address register has its own clock, which runs independently of the system clock. A decoder turns the stored address into a one-hot select. On a system clock edge in test mode, only the selected cell loads the serial scan input and every other cell holds. The serial scan output shows the selected cell's state through a combinational path. Test time therefore grows with the number of cells visited, not with the size of the bank.

Top module: `ras_state_array`

## Requirements
- R1: With `test_mode` low, every cell loads its bit of `func_d` on each rising edge of `clk_sys`, and `func_q` shows all cell states.
- R2: The address register is ceil(log2(NUM_CELLS)) bits wide. On each rising edge of `clk_addr` its contents move up one bit and `addr_sin` enters bit 0. A full address is therefore shifted in most significant bit first.
- R3: The address register changes only on `clk_addr`. Edges of `clk_sys` in either mode leave it unchanged, and it shifts whatever the level of `test_mode`.
- R4: At most one cell is selected at any time, and it is the cell whose index equals the stored address.
- R5: With `test_mode` high, the selected cell loads `scan_in` on the rising edge of `clk_sys`.
- R6: With `test_mode` high, cells that are not selected keep their value across `clk_sys` edges.
- R7: `scan_out` equals the state of the selected cell in either mode. It follows combinationally from the address and the cell states.
- R8: A stored address equal to or above NUM_CELLS selects no cell. `scan_out` then reads 0, and a test-mode `clk_sys` edge changes no cell.
- R9: While `rst_n` is low, every cell and the address register are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the state cells |
| clk_addr | input | 1 | Address shift clock, independent of clk_sys |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = scan access, 0 = functional capture |
| addr_sin | input | 1 | Serial address input, MSB first |
| scan_in | input | 1 | Serial data written to the selected cell |
| scan_out | output | 1 | State of the selected cell, 0 when none is selected |
| func_d | input | NUM_CELLS | Functional next-state bus |
| func_q | output | NUM_CELLS | Cell states driving the functional logic |

## Verification
The assertions check on every cycle that each cell captures the functional input in normal mode, captures the scan input only when it is selected in test mode, and otherwise holds. They also check that the select has at most one bit set, that an out-of-range address selects nothing, that a new address bit enters at the bottom on each address clock, and that the scan output matches the cell the address points to. Only the bench's scenarios show that a whole address shifted in most significant bit first reaches the intended cell, that system clock edges leave the stored address alone, and that a sequence of scattered reads and writes builds the intended bank contents.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Address width for a bank of n cells; never below one bit.
  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg #(
  parameter int AW = 4
) (
  input  logic          clk_addr,
  input  logic          rst_n,
  input  logic          addr_sin,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_next;

  generate
    if (AW > 1) begin : g_wide
      always_comb addr_next = {addr_q[AW-2:0], addr_sin};
    end else begin : g_narrow
      always_comb addr_next = addr_sin;
    end
  endgenerate

  always_ff @(posedge clk_addr or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_next;
  end

  AST_ADDR_SHIFT_IN: assert property (@(posedge clk_addr) disable iff (!rst_n)
    1'b1 |=> addr_q[0] == $past(addr_sin)); // R2
endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int NUM_CELLS = 12,
  parameter int AW        = 4
) (
  input  logic [AW-1:0]        addr_q,
  output logic [NUM_CELLS-1:0] sel
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_sel
    localparam logic [AW-1:0] IDX = AW'(i);
    assign sel[i] = (addr_q == IDX);
  end
endmodule

// File: rtl/ras_cell.sv
module ras_cell (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic test_mode,
  input  logic sel,
  input  logic func_d,
  input  logic scan_in,
  output logic q
);
  logic cell_en;
  logic d_next;

  always_comb begin
    cell_en = !test_mode || sel;
    d_next  = test_mode ? scan_in : func_d;
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (cell_en) q <= d_next;
  end

  AST_FUNC_LOAD: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !test_mode |=> q == $past(func_d)); // R1
  AST_SCAN_LOAD: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (test_mode && sel) |=> q == $past(scan_in)); // R5
  AST_HOLD_UNSEL: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (test_mode && !sel) |=> $stable(q)); // R6
endmodule

// File: rtl/ras_state_array.sv
module ras_state_array #(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk_sys,
  input  logic                 clk_addr,
  input  logic                 rst_n,
  input  logic                 test_mode,
  input  logic                 addr_sin,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic [NUM_CELLS-1:0] func_d,
  output logic [NUM_CELLS-1:0] func_q
);
  localparam int AW = ras_pkg::addr_width(NUM_CELLS);
  localparam logic [AW:0] CELL_LIMIT = (AW + 1)'(NUM_CELLS);

  logic [AW-1:0]        addr_q;
  logic [NUM_CELLS-1:0] sel;

  ras_addr_reg #(.AW(AW)) u_addr (
    .clk_addr (clk_addr),
    .rst_n    (rst_n),
    .addr_sin (addr_sin),
    .addr_q   (addr_q)
  );

  ras_decoder #(.NUM_CELLS(NUM_CELLS), .AW(AW)) u_dec (
    .addr_q (addr_q),
    .sel    (sel)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    ras_cell u_cell (
      .clk_sys   (clk_sys),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .sel       (sel[i]),
      .func_d    (func_d[i]),
      .scan_in   (scan_in),
      .q         (func_q[i])
    );
  end

  // Read path: AND-OR of the one-hot select with the cell states.
  always_comb scan_out = |(sel & func_q);

  AST_SEL_ONEHOT: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $onehot0(sel)); // R4
  AST_OOR_NO_SEL: assert property (@(posedge clk_sys) disable iff (!rst_n)
    ({1'b0, addr_q} >= CELL_LIMIT) |-> (sel == '0)); // R8
  AST_SCANOUT_MATCH: assert property (@(posedge clk_sys) disable iff (!rst_n)
    scan_out == (({1'b0, addr_q} < CELL_LIMIT) ? func_q[int'(addr_q)] : 1'b0)); // R7
endmodule

// File: tb/ras_state_array_tb.sv
`timescale 1ns/1ps
module ras_state_array_tb;
  localparam int N  = 12;
  localparam int AW = ras_pkg::addr_width(N);

  logic clk_sys = 1'b0;
  logic clk_addr, rst_n, test_mode, addr_sin, scan_in;
  logic scan_out;
  logic [N-1:0] func_d, func_q;

  logic [N-1:0] mq;
  int maddr;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_sys = ~clk_sys;

  ras_state_array #(.NUM_CELLS(N)) u_dut (
    .clk_sys(clk_sys), .clk_addr(clk_addr), .rst_n(rst_n), .test_mode(test_mode),
    .addr_sin(addr_sin), .scan_in(scan_in), .scan_out(scan_out),
    .func_d(func_d), .func_q(func_q)
  );

  function automatic logic exp_out(input logic [N-1:0] st, input int a);
    return (a < N) ? st[a] : 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_sys);
    @(negedge clk_sys);
  endtask

  // Shift one bit; cells reload their own state meanwhile (R3 scenario).
  task automatic shift_bit(input logic b);
    test_mode = 1'b0;
    func_d    = mq;
    addr_sin  = b;
    #1 clk_addr = 1'b1;
    #1 clk_addr = 1'b0;
    maddr = ((maddr << 1) | int'(b)) & ((1 << AW) - 1);
  endtask

  task automatic load_addr(input int a);
    for (int i = AW - 1; i >= 0; i--) shift_bit(a[i]);
    @(negedge clk_sys);
  endtask

  task automatic scan_write(input int a, input logic v);
    load_addr(a);
    check(scan_out === exp_out(mq, a), "R7 read before write", scan_out, exp_out(mq, a));
    test_mode = 1'b1;
    scan_in   = v;
    func_d    = ~mq;
    tick();
    if (a < N) mq[a] = v;
    check(func_q === mq, (a < N) ? "R5/R6 scan write" : "R8 out-of-range write", func_q, mq);
    check(scan_out === exp_out(mq, a), "R7 read after write", scan_out, exp_out(mq, a));
  endtask

  initial begin
    void'($urandom(32'd4242));
    clk_addr = 0; rst_n = 0; test_mode = 0; addr_sin = 0; scan_in = 0;
    func_d = '1; mq = '0; maddr = 0;
    repeat (3) @(negedge clk_sys);
    check(func_q === '0, "R9 reset cells", func_q, 0);
    check(scan_out === 1'b0, "R9 reset scan_out", scan_out, 0);
    rst_n = 1'b1;
    @(negedge clk_sys);

    // R1: functional capture with random patterns
    for (int k = 0; k < 20; k++) begin
      func_d = N'($urandom);
      test_mode = 1'b0;
      tick();
      mq = func_d;
      check(func_q === mq, "R1 functional load", func_q, mq);
      check(scan_out === exp_out(mq, maddr), "R7 normal-mode read", scan_out, exp_out(mq, maddr));
    end

    // Directed corners: first cell, last cell, first and top out-of-range addresses
    scan_write(0, ~mq[0]);
    scan_write(N - 1, ~mq[N-1]);
    scan_write(N, 1'b1);
    check(scan_out === 1'b0, "R8 out-of-range reads 0", scan_out, 0);
    scan_write((1 << AW) - 1, 1'b0);

    // R2: one extra bit shifts the stored address up
    load_addr(2);
    shift_bit(1'b1);
    @(negedge clk_sys);
    check(maddr == 5, "R2 model shift", maddr, 5);
    check(scan_out === exp_out(mq, 5), "R2 partial shift read", scan_out, exp_out(mq, 5));

    // R3: system clock edges do not disturb the address
    load_addr(7);
    for (int k = 0; k < 4; k++) begin
      test_mode = 1'b0;
      func_d = N'($urandom);
      tick();
      mq = func_d;
      check(scan_out === exp_out(mq, 7), "R3 address stable over clk_sys", scan_out, exp_out(mq, 7));
    end

    // Random mix of scan reads/writes
    for (int k = 0; k < 60; k++) begin
      int a;
      a = int'($urandom % (1 << AW));
      scan_write(a, 1'($urandom));
    end

    // R4: walk all in-range addresses with a known pattern, read back one at a time
    for (int a = 0; a < N; a++) scan_write(a, 1'(a % 3 == 0));
    for (int a = 0; a < N; a++) begin
      load_addr(a);
      check(scan_out === 1'(a % 3 == 0), "R4 addressed cell only", scan_out, 1'(a % 3 == 0));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule